// File: doc/BRIEF.md
# Multiplexed LCD Backplane Drive Sequencer

This block steps through the backplane time slots of a passive LCD and, for every slot, turns one row of display memory into drive level codes for four backplane pins and a parameterised number of segment pins (60 by default). It supports static drive and 1:2, 1:3 and 1:4 multiplexing, with static, 1/2 or 1/3 bias. Each output carries a 2-bit code naming a fraction of the LCD supply; an analog stage outside the block turns the codes into voltages. The display memory sits outside too and is read one row at a time through a synchronous read port, row k holding bit k of every column.

A frame-rate clock enable advances the slot. Drive mode, bias, bank choice and blink enable are sampled only at frame boundaries, so a change never cuts a frame short. Polarity flips every frame so that each segment sees no net DC. Several devices can share an open-drain, active-low sync wire: each pulls it low during its last active slot and snaps its own sequence to that slot when it sees another device pull it. A blink divider can blank all segments for whole groups of frames.

Top module: `lcd_bp_sequencer`

## Requirements
- R1: While `rst` is high, every backplane and segment code is 0 (ground) from the second clock edge of reset on.
- R2: After reset the block runs 1:4 multiplex, 1/3 bias, bank 0, blink off, slot 0, normal polarity. The configuration inputs are loaded only when a `frame_tick` ends a frame (the tick taken in the last active slot).
- R3: Mode codes are 0 static, 1 for 1:2, 2 for 1:3 and 3 for 1:4; the number of active slots is the code plus one. Each `frame_tick` moves the slot to the next one, and the tick in the last slot returns to slot 0.
- R4: In 1:3 and 1:4 modes, `mem_row` equals the current slot number, so memory bit k is shown while backplane k is active.
- R5: In static mode `mem_row` equals `disp_bank`. In 1:2 mode it is {`disp_bank[1]`, slot bit 0}, choosing bit pair {0,1} or {2,3}. In 1:3 and 1:4 modes `disp_bank` has no effect.
- R6: Codes are 0 ground, 1 low middle, 2 high middle, 3 full. Bias codes are 0 static, 1 half, 2 third (3 acts as third). At 1/3 bias in the normal-polarity frame, the active backplane is 3, other used backplanes are 1, an on segment is 0 and an off segment is 2. In the inverted frame these become 0, 2, 3 and 1.
- R7: At 1/2 bias the active backplane and on segments follow R6, while inactive used backplanes and off segments are code 1 in both polarities.
- R8: At static bias, inactive used backplanes and off segments carry the same code as the active backplane, and on segments carry the opposite extreme.
- R9: Backplanes whose index exceeds the mode code output code 0.
- R10: Polarity starts normal after reset and inverts at every frame end.
- R11: `sync_oe` is 1 and `sync_out` is 0 exactly while the slot is the last active slot; otherwise `sync_oe` is 0.
- R12: If `sync_in` is low in a cycle where the block is not in its last slot, the slot becomes the last slot at the next clock edge, with no frame end and no polarity change. The following `frame_tick` starts slot 0.
- R13: With blink enabled (taking effect at a frame end), BLINK_FRAMES frames are shown normally, then BLINK_FRAMES frames have every segment forced to its off code, and this alternates. Backplanes are unaffected. Disabling blink ends blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | Slot advance enable, one cycle per slot |
| drive_mode | input | 2 | Multiplex mode code |
| bias_sel | input | 2 | Bias code |
| disp_bank | input | 2 | Bank choice for static and 1:2 modes |
| blink_en | input | 1 | Whole-display blink enable |
| mem_row | output | 2 | Display memory row address |
| mem_rdata | input | NUM_SEG | Row data, one clock after the address |
| sync_in | input | 1 | Level of the shared sync wire, active low |
| sync_out | output | 1 | Sync drive value (low when driving) |
| sync_oe | output | 1 | Sync output enable |
| bp_level | output | 8 | Backplane codes, backplane k at bits 2k+1:2k |
| seg_level | output | 2*NUM_SEG | Segment codes, segment j at bits 2j+1:2j |

## Verification
The bench builds the block with NUM_SEG = 8 and BLINK_FRAMES = 3. Eight segments are enough to cover every mix of on and off bits through four distinct memory rows. A three-frame blink period lets a short run in 1:2 mode pass through several full show and blank phases and also the exit from blinking. The sync wire is modelled as a wired-low net combining the block's own drive with a pull from the bench, so both the driving side and the jump to the last slot are exercised.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int NBP = 4;

  localparam logic [1:0] MODE_STATIC  = 2'd0;
  localparam logic [1:0] MODE_DUPLEX  = 2'd1;
  localparam logic [1:0] MODE_TRIPLEX = 2'd2;
  localparam logic [1:0] MODE_QUAD    = 2'd3;

  localparam logic [1:0] BIAS_STATIC = 2'd0;
  localparam logic [1:0] BIAS_HALF   = 2'd1;
  localparam logic [1:0] BIAS_THIRD  = 2'd2;

  localparam logic [1:0] LV_GND  = 2'd0;
  localparam logic [1:0] LV_LOW  = 2'd1;
  localparam logic [1:0] LV_HIGH = 2'd2;
  localparam logic [1:0] LV_FULL = 2'd3;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] bias;
    logic [1:0] bank;
    logic       blink;
  } seq_cfg_t;

  localparam seq_cfg_t CFG_RESET = '{mode: MODE_QUAD, bias: BIAS_THIRD,
                                     bank: 2'd0, blink: 1'b0};

  // memory row shown in a given slot
  function automatic logic [1:0] row_for_slot(input seq_cfg_t c, input logic [1:0] s);
    case (c.mode)
      MODE_STATIC: return c.bank;
      MODE_DUPLEX: return {c.bank[1], s[0]};
      default:     return s;
    endcase
  endfunction
endpackage

// File: rtl/lcd_slot_ctrl.sv
module lcd_slot_ctrl
  import lcd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  seq_cfg_t   cfg_in,
  input  logic       sync_in,
  output logic [1:0] slot,
  output logic       phase,
  output seq_cfg_t   cfg_q,
  output logic       frame_end,
  output logic       sync_drive
);
  logic sync_seen;

  assign sync_drive = (slot == cfg_q.mode);
  assign sync_seen  = !sync_in && !sync_drive;
  assign frame_end  = tick && !sync_seen && (slot >= cfg_q.mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot  <= 2'd0;
      phase <= 1'b0;
      cfg_q <= CFG_RESET;
    end else if (sync_seen) begin
      slot <= cfg_q.mode;
    end else if (frame_end) begin
      slot  <= 2'd0;
      phase <= ~phase;
      cfg_q <= cfg_in;
    end else if (tick) begin
      slot <= slot + 2'd1;
    end
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && sync_in && slot < cfg_q.mode) |=> (slot == $past(slot) + 2'd1)); // R3

  AST_SYNC_JUMP: assert property (@(posedge clk) disable iff (rst)
    (!sync_in && slot != cfg_q.mode) |=> (slot == $past(cfg_q.mode))); // R12

  AST_PHASE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase) |-> $past(tick && slot >= cfg_q.mode)); // R10
endmodule

// File: rtl/lcd_blink.sv
module lcd_blink #(
  parameter int BLINK_FRAMES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic blink_on,
  input  logic frame_end,
  output logic blank
);
  localparam int CW = (BLINK_FRAMES > 2) ? $clog2(BLINK_FRAMES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(BLINK_FRAMES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !blink_on) begin
      cnt   <= '0;
      blank <= 1'b0;
    end else if (frame_end) begin
      if (cnt == CNT_LAST) begin
        cnt   <= '0;
        blank <= ~blank;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_NO_BLANK_OFF: assert property (@(posedge clk) disable iff (rst)
    !blink_on |=> !blank); // R13
endmodule

// File: rtl/lcd_level_gen.sv
module lcd_level_gen
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG = 60
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             slot,
  input  logic                   phase,
  input  seq_cfg_t               cfg,
  input  logic                   blank,
  input  logic [NUM_SEG-1:0]     row_bits,
  output logic [2*NBP-1:0]       bp_lv,
  output logic [2*NUM_SEG-1:0]   seg_lv
);
  // state delayed one cycle to line up with the memory read data
  logic [1:0] s1_slot, s1_mode, s1_bias;
  logic       s1_phase, s1_blank;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_slot  <= 2'd0;
      s1_mode  <= MODE_QUAD;
      s1_bias  <= BIAS_THIRD;
      s1_phase <= 1'b0;
      s1_blank <= 1'b0;
    end else begin
      s1_slot  <= slot;
      s1_mode  <= cfg.mode;
      s1_bias  <= cfg.bias;
      s1_phase <= phase;
      s1_blank <= blank;
    end
  end

  logic [1:0] lv_act, lv_on, lv_idle, lv_off;

  always_comb begin
    lv_act = s1_phase ? LV_GND : LV_FULL;
    lv_on  = s1_phase ? LV_FULL : LV_GND;
    case (s1_bias)
      BIAS_HALF: begin
        lv_idle = LV_LOW;
        lv_off  = LV_LOW;
      end
      BIAS_STATIC: begin
        lv_idle = lv_act;
        lv_off  = lv_act;
      end
      default: begin
        lv_idle = s1_phase ? LV_HIGH : LV_LOW;
        lv_off  = s1_phase ? LV_LOW : LV_HIGH;
      end
    endcase
  end

  logic [NBP-1:0][1:0]     bp_next, bp_q;
  logic [NUM_SEG-1:0][1:0] seg_next, seg_q;

  for (genvar k = 0; k < NBP; k++) begin : g_bp
    localparam logic [1:0] KI = 2'(k);
    assign bp_next[k] = (KI == s1_slot) ? lv_act :
                        (KI <= s1_mode) ? lv_idle : LV_GND;
  end

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
    assign seg_next[j] = (row_bits[j] && !s1_blank) ? lv_on : lv_off;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_q  <= '0;
      seg_q <= '0;
    end else begin
      bp_q  <= bp_next;
      seg_q <= seg_next;
    end
  end

  assign bp_lv  = bp_q;
  assign seg_lv = seg_q;

  AST_RESET_ZERO: assert property (@(posedge clk)
    $past(rst) |-> (bp_q == '0 && seg_q == '0)); // R1
endmodule

// File: rtl/lcd_bp_sequencer.sv
module lcd_bp_sequencer
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG      = 60,
  parameter int BLINK_FRAMES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_tick,
  input  logic [1:0]           drive_mode,
  input  logic [1:0]           bias_sel,
  input  logic [1:0]           disp_bank,
  input  logic                 blink_en,
  output logic [1:0]           mem_row,
  input  logic [NUM_SEG-1:0]   mem_rdata,
  input  logic                 sync_in,
  output logic                 sync_out,
  output logic                 sync_oe,
  output logic [2*NBP-1:0]     bp_level,
  output logic [2*NUM_SEG-1:0] seg_level
);
  seq_cfg_t   cfg_in, cfg_q;
  logic [1:0] slot;
  logic       phase, frame_end, sync_drive, blank;

  assign cfg_in = '{mode: drive_mode, bias: bias_sel, bank: disp_bank, blink: blink_en};

  lcd_slot_ctrl u_slot (
    .clk        (clk),
    .rst        (rst),
    .tick       (frame_tick),
    .cfg_in     (cfg_in),
    .sync_in    (sync_in),
    .slot       (slot),
    .phase      (phase),
    .cfg_q      (cfg_q),
    .frame_end  (frame_end),
    .sync_drive (sync_drive)
  );

  lcd_blink #(.BLINK_FRAMES(BLINK_FRAMES)) u_blink (
    .clk       (clk),
    .rst       (rst),
    .blink_on  (cfg_q.blink),
    .frame_end (frame_end),
    .blank     (blank)
  );

  lcd_level_gen #(.NUM_SEG(NUM_SEG)) u_level (
    .clk      (clk),
    .rst      (rst),
    .slot     (slot),
    .phase    (phase),
    .cfg      (cfg_q),
    .blank    (blank),
    .row_bits (mem_rdata),
    .bp_lv    (bp_level),
    .seg_lv   (seg_level)
  );

  assign mem_row  = row_for_slot(cfg_q, slot);
  assign sync_oe  = sync_drive;
  assign sync_out = ~sync_drive;
endmodule

// File: tb/sim_lcd_bp_sequencer.sv
module sim_lcd_bp_sequencer;
  localparam int NSEG = 8;
  localparam int BF   = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, frame_tick = 1'b0, blink_en = 1'b0, ext_low = 1'b0;
  logic [1:0] drive_mode = 2'd0, bias_sel = 2'd1, disp_bank = 2'd2;
  logic [1:0] mem_row;
  logic sync_in, sync_out, sync_oe;
  logic [7:0] bp_level;
  logic [2*NSEG-1:0] seg_level;
  logic [NSEG-1:0] rows [4];
  logic [NSEG-1:0] mem_rdata;

  assign sync_in = ext_low ? 1'b0 : (sync_oe ? sync_out : 1'b1);
  always_ff @(posedge clk) mem_rdata <= rows[mem_row];

  lcd_bp_sequencer #(.NUM_SEG(NSEG), .BLINK_FRAMES(BF)) u0 (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .drive_mode(drive_mode),
    .bias_sel(bias_sel), .disp_bank(disp_bank), .blink_en(blink_en),
    .mem_row(mem_row), .mem_rdata(mem_rdata), .sync_in(sync_in),
    .sync_out(sync_out), .sync_oe(sync_oe), .bp_level(bp_level),
    .seg_level(seg_level));

  int checks = 0, errors = 0;
  int m_slot, m_phase, m_mode, m_bias, m_bank, m_blink, m_bcnt, m_blank;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_slot = 0; m_phase = 0; m_mode = 3; m_bias = 2; m_bank = 0;
    m_blink = 0; m_bcnt = 0; m_blank = 0;
  endtask

  task automatic check_state(string tag);
    logic [1:0] act_c, on_c, idle_c, off_c, row;
    logic [7:0] ebp;
    logic [2*NSEG-1:0] eseg;
    act_c = m_phase ? 2'd0 : 2'd3;
    on_c  = m_phase ? 2'd3 : 2'd0;
    if (m_bias == 1) begin idle_c = 2'd1; off_c = 2'd1; end
    else if (m_bias == 0) begin idle_c = act_c; off_c = act_c; end
    else begin idle_c = m_phase ? 2'd2 : 2'd1; off_c = m_phase ? 2'd1 : 2'd2; end
    for (int k = 0; k < 4; k++)
      ebp[2*k +: 2] = (k == m_slot) ? act_c : (k <= m_mode) ? idle_c : 2'd0;
    if (m_mode == 0) row = 2'(m_bank);
    else if (m_mode == 1) row = {m_bank[1], m_slot[0]};
    else row = 2'(m_slot);
    for (int j = 0; j < NSEG; j++)
      eseg[2*j +: 2] = (rows[row][j] && m_blank == 0) ? on_c : off_c;
    chk(tag, "mem_row", 32'(mem_row), 32'(row));
    chk(tag, "bp_level", 32'(bp_level), 32'(ebp));
    chk(tag, "seg_level", 32'(seg_level), 32'(eseg));
    chk(tag, "sync_oe", 32'(sync_oe), 32'(m_slot == m_mode));
    chk(tag, "sync_out", 32'(sync_out), 32'(m_slot != m_mode));
  endtask

  task automatic do_tick(string tag);
    @(negedge clk) frame_tick = 1'b1;
    if (m_slot >= m_mode) begin
      m_slot = 0; m_phase ^= 1;
      if (m_blink != 0) begin
        if (m_bcnt == BF - 1) begin m_bcnt = 0; m_blank ^= 1; end
        else m_bcnt++;
      end
      m_mode = drive_mode; m_bias = bias_sel; m_bank = disp_bank; m_blink = blink_en;
      if (m_blink == 0) begin m_bcnt = 0; m_blank = 0; end
    end else m_slot++;
    @(negedge clk) frame_tick = 1'b0;
    repeat (3) @(negedge clk);
    check_state(tag);
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) do_tick(tag);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "bp_level", 32'(bp_level), 32'd0);
    chk("R1", "seg_level", 32'(seg_level), 32'd0);
    rst = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check_state("R2");
    run("R2/R3", 4);
  endtask

  task automatic t_static();
    bias_sel = 2'd0;
    for (int b = 0; b < 4; b++) begin
      disp_bank = 2'(b);
      run("R5/R8", 2);
    end
  endtask

  task automatic t_quad();
    drive_mode = 2'd3; bias_sel = 2'd2; disp_bank = 2'd3;
    run("R3/R4/R5/R6/R10/R11", 9);
  endtask

  task automatic t_triplex();
    drive_mode = 2'd2; bias_sel = 2'd3;
    run("R4/R9/R6", 8);
  endtask

  task automatic t_duplex();
    drive_mode = 2'd1; bias_sel = 2'd1; disp_bank = 2'd0;
    run("R5/R7", 5);
    disp_bank = 2'd2;
    run("R5/R7", 5);
  endtask

  task automatic t_sync();
    drive_mode = 2'd3; bias_sel = 2'd2; disp_bank = 2'd0;
    run("R12", 3);
    while (m_slot != 1) do_tick("R12");
    @(negedge clk) ext_low = 1'b1;
    @(negedge clk) ext_low = 1'b0;
    m_slot = m_mode;
    repeat (3) @(negedge clk);
    check_state("R12");
    do_tick("R12");
    chk("R12", "slot0 bp0 active", 32'(bp_level[1:0]), 32'(m_phase ? 2'd0 : 2'd3));
    run("R11/R12", 3);
  endtask

  task automatic t_blink();
    drive_mode = 2'd1; bias_sel = 2'd2; blink_en = 1'b1;
    run("R13", 26);
    blink_en = 1'b0;
    run("R13", 5);
  endtask

  initial begin
    rows[0] = 8'hA5; rows[1] = 8'h3C; rows[2] = 8'hF0; rows[3] = 8'h0F;
    model_reset();
    t_reset();
    t_static();
    t_quad();
    t_triplex();
    t_duplex();
    t_sync();
    t_blink();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired before the end of the tests");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule